// File: doc/BRIEF.md
# Ethernet Pause-Frame Flow Controller

This block tells an Ethernet MAC transmitter when to emit an IEEE 802.3 pause control frame and which 16-bit pause-time value goes into it. It holds the software flow-control enable bit. When the link runs full duplex, setting that bit asks for a pause frame that carries the programmed pause time. Clearing the bit asks for a release frame that carries zero.

There are two modes, chosen by the repeat interval. If the interval is nonzero, a repeat counter advances once per pause quantum (512 bit times). Each time it reaches the interval, the block asks for a fresh pause frame, so the partner stays paused for as long as the enable remains set. If the interval is zero, the block sends a single frame and counts quanta on a pause counter. When that count reaches the pause time, the block clears the enable bit itself, and software can poll the bit to see that the pause has ended.

Each request is held until the transmitter reports it done. The frame bytes, the CRC and the register bus are handled by neighbouring logic.

Top module: `pause_flow_ctl`

## Requirements
- R1: While `fd_en` is 1, a software write that turns `en` from 0 to 1 raises `req` on the next clock, with `req_time` equal to `pause_time`. While `fd_en` is 0, `req` stays 0 and `status` reads 0.
- R2: Once raised, `req` stays 1 and `req_time` stays unchanged until a cycle with `tx_done` high. No counter advances while `req` is 1.
- R3: While `fd_en` is 1, a software write that turns `en` from 1 to 0 raises `req` with `req_time` equal to 0. If a frame is still pending at that moment, its value is replaced by 0 and only one frame is requested.
- R4: When `repeat_ival` is nonzero, `status` reads 0 once a frame's `tx_done` has been seen. It then rises by one for each `quantum` pulse.
- R5: In repeat mode, the quantum that brings the repeat count to at least `repeat_ival` while `en` is 1 does three things on that clock: it raises `req` with `req_time` equal to `pause_time`, returns `status` to 0, and lets the cycle repeat after each `tx_done`.
- R6: When `repeat_ival` is 0, the quantum that brings the pause count to at least `pause_time` drives `hw_clr` to 1 in that cycle. After that clock, `en` reads 0, `status` holds the final count and no release frame is requested.
- R7: `status` shows the repeat count when `repeat_ival` is nonzero, and the pause count when it is 0.
- R8: A change to `repeat_ival` takes effect at once. Both counts advance in every mode, saturating at all ones, and the next quantum compares the count of the newly selected mode.
- R9: When a software write (`sw_we`) and `hw_clr` fall in the same cycle, `en` takes the written value.
- R10: A synchronous `rst` clears `en`, `req` and both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fd_en | input | 1 | Link is in full duplex |
| sw_we | input | 1 | Software write strobe for the enable bit |
| sw_val | input | 1 | Value written to the enable bit |
| pause_time | input | W | Pause time placed in pause frames |
| repeat_ival | input | W | Repeat interval in quanta; 0 selects single-shot mode |
| quantum | input | 1 | One-cycle pulse every 512 bit times |
| tx_done | input | 1 | Transmitter has sent the requested frame |
| req | output | 1 | Pause frame request |
| req_time | output | W | Pause time for the requested frame |
| en | output | 1 | Current flow-control enable bit |
| hw_clr | output | 1 | Hardware clear of the enable bit (single-shot timeout) |
| status | output | W | Selected internal count |

## Verification
The bench builds the block with `W = 8`. At that width it can sweep every repeat interval from 1 to 5 and every single-shot pause time from 0 to 5, and for each one it walks through each count value, checking against arithmetic expectations. It also covers release-while-pending, the same-cycle write/clear priority, switching between modes in the middle of a count, a half-duplex link, and a reset in mid-operation.

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fd_en,
  input  logic         sw_we,
  input  logic         sw_val,
  input  logic [W-1:0] pause_time,
  input  logic [W-1:0] repeat_ival,
  input  logic         quantum,
  input  logic         tx_done,
  output logic         req,
  output logic [W-1:0] req_time,
  output logic         en,
  output logic         hw_clr,
  output logic [W-1:0] status
);

  logic         en_q, req_q, act_q;
  logic [W-1:0] rt_q, rpt_q, pz_q;

  wire         rpt_mode = |repeat_ival;
  wire         rise     = fd_en & sw_we & sw_val & ~en_q;
  wire         fall     = fd_en & sw_we & ~sw_val & en_q;
  wire         tick     = fd_en & act_q & ~req_q & quantum;
  wire         sent     = tx_done & req_q;
  wire [W:0]   rpt_inc  = {1'b0, rpt_q} + 1'b1;
  wire [W:0]   pz_inc   = {1'b0, pz_q} + 1'b1;
  wire [W-1:0] rpt_nx   = rpt_inc[W] ? rpt_q : rpt_inc[W-1:0];
  wire [W-1:0] pz_nx    = pz_inc[W] ? pz_q : pz_inc[W-1:0];
  wire         rpt_fire = tick & rpt_mode & en_q & (rpt_inc >= {1'b0, repeat_ival});
  wire         pz_end   = tick & ~rpt_mode & en_q & (pz_inc >= {1'b0, pause_time});
  wire         keep_on  = sw_we & sw_val;

  assign hw_clr   = pz_end;
  assign req      = req_q;
  assign req_time = rt_q;
  assign en       = en_q;
  assign status   = rpt_mode ? rpt_q : pz_q;

  always_ff @(posedge clk) begin
    if (rst)            en_q <= 1'b0;
    else if (sw_we)     en_q <= sw_val;
    else if (pz_end)    en_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !fd_en) begin
      req_q <= 1'b0;
      rt_q  <= '0;
    end else if (fall) begin
      req_q <= 1'b1;
      rt_q  <= '0;
    end else if (rise || rpt_fire) begin
      req_q <= 1'b1;
      rt_q  <= pause_time;
    end else if (sent) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !fd_en || rise || fall)  act_q <= 1'b0;
    else if (sent)                      act_q <= en_q;
    else if (pz_end && !keep_on)        act_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !fd_en || rise || fall || sent) begin
      rpt_q <= '0;
      pz_q  <= '0;
    end else if (rpt_fire) begin
      rpt_q <= '0;
      pz_q  <= pz_nx;
    end else if (tick) begin
      rpt_q <= rpt_nx;
      pz_q  <= pz_nx;
    end
  end

endmodule

// File: rtl/pause_flow_ctl_chk.sv
module pause_flow_ctl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         fd_en,
  input logic         sw_we,
  input logic         sw_val,
  input logic         tx_done,
  input logic         req,
  input logic [W-1:0] req_time,
  input logic         en,
  input logic         hw_clr,
  input logic [W-1:0] status
);

  p_halfdup_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !fd_en |=> (!req && status == '0));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !tx_done && fd_en && !sw_we) |=> (req && req_time == $past(req_time)));

  p_release_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (fd_en && sw_we && !sw_val && en) |=> (req && req_time == '0));

  p_hwclr_drops_en_r6: assert property (@(posedge clk) disable iff (rst)
    (hw_clr && !sw_we) |=> !en);

  p_sw_priority_r9: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (en == $past(sw_val)));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!req && !en && status == '0));

endmodule

bind pause_flow_ctl pause_flow_ctl_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .fd_en(fd_en), .sw_we(sw_we), .sw_val(sw_val),
  .tx_done(tx_done), .req(req), .req_time(req_time), .en(en),
  .hw_clr(hw_clr), .status(status)
);

// File: tb/test_pause_flow_ctl.sv
module test_pause_flow_ctl;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1, fd_en = 1'b0, sw_we = 1'b0, sw_val = 1'b0;
  logic quantum = 1'b0, tx_done = 1'b0;
  logic [W-1:0] pause_time = '0, repeat_ival = '0;
  logic req, en, hw_clr;
  logic [W-1:0] req_time, status;
  int n_run = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  pause_flow_ctl #(.W(W)) i_pause_flow_ctl (
    .clk(clk), .rst(rst), .fd_en(fd_en), .sw_we(sw_we), .sw_val(sw_val),
    .pause_time(pause_time), .repeat_ival(repeat_ival), .quantum(quantum),
    .tx_done(tx_done), .req(req), .req_time(req_time), .en(en),
    .hw_clr(hw_clr), .status(status)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(bit v);
    sw_we = 1'b1; sw_val = v; step(); sw_we = 1'b0;
  endtask

  task automatic qpulse();
    quantum = 1'b1; step(); quantum = 1'b0;
  endtask

  task automatic dpulse();
    tx_done = 1'b1; step(); tx_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    step();
    chk("R10 reset req", int'(req), 0);
    chk("R10 reset en", int'(en), 0);
    chk("R10 reset status", int'(status), 0);

    // R1: half duplex, nothing requested
    pause_time = 8'd4; repeat_ival = 8'd2;
    wr(1'b1);
    qpulse(); qpulse(); qpulse();
    chk("R1 half duplex req", int'(req), 0);
    chk("R1 half duplex status", int'(status), 0);
    wr(1'b0);

    fd_en = 1'b1;
    step();

    // R4 / R5 repeat sweep
    for (int iv = 1; iv <= 5; iv++) begin
      repeat_ival = iv[W-1:0];
      pause_time = 8'(20 + iv);
      wr(1'b1);
      chk("R1 rise req", int'(req), 1);
      chk("R1 rise value", int'(req_time), 20 + iv);
      qpulse(); qpulse(); step();
      chk("R2 held req", int'(req), 1);
      chk("R2 held value", int'(req_time), 20 + iv);
      chk("R2 no count while pending", int'(status), 0);
      for (int rnd = 0; rnd < 2; rnd++) begin
        dpulse();
        chk("R2 done drops req", int'(req), 0);
        chk("R4 status zero after done", int'(status), 0);
        for (int k = 1; k < iv; k++) begin
          qpulse();
          chk("R4 repeat count", int'(status), k);
          chk("R5 no early repeat", int'(req), 0);
        end
        qpulse();
        chk("R5 repeat req", int'(req), 1);
        chk("R5 repeat value", int'(req_time), 20 + iv);
        chk("R5 count wraps", int'(status), 0);
      end
      dpulse();
      qpulse();
      wr(1'b0);
      chk("R3 release req", int'(req), 1);
      chk("R3 release value", int'(req_time), 0);
      dpulse();
      qpulse(); qpulse();
      chk("R3 single release", int'(req), 0);
      chk("R7 idle status", int'(status), 0);
    end

    // R6 single-shot sweep
    repeat_ival = '0;
    for (int pt = 0; pt <= 5; pt++) begin
      pause_time = pt[W-1:0];
      wr(1'b1);
      chk("R1 single rise value", int'(req_time), pt);
      dpulse();
      for (int k = 1; k < pt; k++) begin
        qpulse();
        chk("R7 pause count", int'(status), k);
        chk("R6 still enabled", int'(en), 1);
      end
      quantum = 1'b1;
      #1;
      chk("R6 hw clear pulse", int'(hw_clr), 1);
      step(); quantum = 1'b0;
      chk("R6 enable cleared", int'(en), 0);
      chk("R6 no release frame", int'(req), 0);
      chk("R6 final count", int'(status), (pt == 0) ? 1 : pt);
      qpulse();
      chk("R6 count stops", int'(status), (pt == 0) ? 1 : pt);
      chk("R6 still no frame", int'(req), 0);
    end

    // R3 release while pending
    pause_time = 8'd9; repeat_ival = 8'd3;
    wr(1'b1);
    wr(1'b0);
    chk("R3 pending replaced req", int'(req), 1);
    chk("R3 pending replaced value", int'(req_time), 0);
    dpulse();
    step(); step();
    chk("R3 only one frame", int'(req), 0);

    // R9 priority
    repeat_ival = '0; pause_time = 8'd1;
    wr(1'b1);
    dpulse();
    quantum = 1'b1; sw_we = 1'b1; sw_val = 1'b1;
    #1;
    chk("R9 clear raised", int'(hw_clr), 1);
    step(); quantum = 1'b0; sw_we = 1'b0;
    chk("R9 write wins", int'(en), 1);
    wr(1'b0);
    dpulse();

    // R8 mode switch
    pause_time = 8'd10; repeat_ival = 8'd3;
    wr(1'b1);
    dpulse();
    qpulse(); qpulse();
    chk("R8 repeat count", int'(status), 2);
    repeat_ival = '0;
    #1;
    chk("R8 shows pause count", int'(status), 2);
    step();
    qpulse(); qpulse(); qpulse();
    chk("R8 pause count", int'(status), 5);
    chk("R8 no timeout yet", int'(en), 1);
    repeat_ival = 8'd2;
    #1;
    chk("R8 shows repeat count", int'(status), 5);
    step();
    qpulse();
    chk("R8 new interval fires", int'(req), 1);
    chk("R8 fired value", int'(req_time), 10);
    chk("R8 count cleared", int'(status), 0);

    // R1 link drop, R10 reset mid-operation
    fd_en = 1'b0; step();
    chk("R1 link drop req", int'(req), 0);
    chk("R1 link drop status", int'(status), 0);
    fd_en = 1'b1;
    wr(1'b0); wr(1'b1);
    dpulse(); qpulse();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R10 mid reset req", int'(req), 0);
    chk("R10 mid reset en", int'(en), 0);
    chk("R10 mid reset status", int'(status), 0);

    finish_run();
  end
endmodule